// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block records requests on a group of interrupt lines (eight by default) in a request register. Each line has its own trigger-mode bit. In level mode the request copies the line. In edge mode only a low-to-high change of the sampled level raises the request, and the request then stays until an acknowledge clears it. Every line keeps a last-seen level that is rewritten each cycle. As a result, a line that is still high after its request was cleared does not raise the request again, and switching a high line from level to edge mode does not raise it either.

Each line is a small state machine with four named states, encoded as {request, last-seen}: `LN_QUIET` (00, no request, line seen low), `LN_HELD` (01, no request, line seen high), `LN_PEND_LO` (10, request pending, line seen low) and `LN_PEND_HI` (11, request pending, line seen high). In level mode every state goes to `LN_PEND_HI` when the line is high and to `LN_QUIET` when it is low. The edge-mode transitions are:
- From `LN_QUIET`: to `LN_PEND_HI` on a high line.
- From `LN_HELD`: to `LN_QUIET` on a low line.
- From `LN_PEND_LO`: to `LN_PEND_HI` on a high line, or to `LN_QUIET` on an acknowledge with the line low.
- From `LN_PEND_HI`: to `LN_PEND_LO` on a low line, to `LN_HELD` on an acknowledge with the line high, or to `LN_QUIET` on an acknowledge with the line low.

A per-line status reports each update. Its codes are `ST_NONE` (0), `ST_NEW` (1) and `ST_MASKED` (2). The trigger-mode register is written through a fixed write mask set by a parameter. Line bits that are zero in that mask always stay in edge mode.

Top module: `irq_req_latch`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every request, every last-seen level and every status field, and sets all lines to edge mode.
- R2: A line in level mode has `req_out[i]` equal to the value `line_in[i]` had at the previous rising edge.
- R3: A line in edge mode sets its request at an edge where `line_in[i]` is 1 and its last-seen level is 0.
- R4: The last-seen level takes the sampled input at every edge, in both modes. An edge-mode line that stays high after its request was cleared, or that was switched from level mode while high, keeps its request at 0 until it has been seen low and then high again.
- R5: In edge mode a falling input leaves a pending request set.
- R6: In edge mode, `ack_clr[i]` high at an edge clears the request, unless a new rising edge is seen in the same cycle, which keeps the request set. In level mode `ack_clr[i]` has no effect.
- R7: The status field of line i is `status_out[2i+1:2i]`. It is 1 (new) when the line is unmasked and the update set a request bit that was 0 before. Otherwise, for an unmasked line, it is 0. The field is registered and describes the most recent update.
- R8: A line with `mask_in[i]` high still updates its request in the normal way, but its status field is 2 (masked) after that edge.
- R9: When `trig_we` is high, the trigger-mode register loads `trig_wdata & TRIG_WMASK`, where 1 means level mode. The new modes govern updates from the next edge onward. With the default mask 0xF8, lines 0 to 2 always stay in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | N_LINES | Synchronous interrupt line levels |
| mask_in | input | N_LINES | Per-line mask, affects status only |
| ack_clr | input | N_LINES | Per-line acknowledge clear for edge-mode requests |
| trig_we | input | 1 | Trigger-mode register write enable |
| trig_wdata | input | N_LINES | Trigger-mode write data, 1 = level |
| req_out | output | N_LINES | Request register |
| status_out | output | 2*N_LINES | Per-line update status (0 none, 1 new, 2 masked) |

## Verification
The bench builds the block with its default parameters: eight lines and write mask 0xF8. With this setup, three lines are forced to edge mode and five can be switched at run time, so one run covers both the forced and the free behaviour. Directed sequences drive every line state into each input combination: rise, fall, acknowledge, acknowledge during a fresh edge, and mode switch while high. A long pseudo-random sweep then drives the inputs, masks, acknowledges and mode writes on all lines together, and compares the results with an arithmetic model.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Per-line state, encoded as {request, last_seen}
    typedef enum logic [1:0] {
        LN_QUIET   = 2'b00,
        LN_HELD    = 2'b01,
        LN_PEND_LO = 2'b10,
        LN_PEND_HI = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        ST_NONE   = 2'd0,
        ST_NEW    = 2'd1,
        ST_MASKED = 2'd2
    } line_status_e;

    localparam int STATUS_W = 2;

endpackage

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
    parameter int                  N_LINES    = 8,
    parameter logic [N_LINES-1:0]  TRIG_WMASK = 8'hF8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [N_LINES-1:0] wr_data,
    output logic [N_LINES-1:0] mode_q
);

    // A bit is writable only where the mask allows level mode.
    logic [N_LINES-1:0] mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = wr_data & TRIG_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                samp,
    input  logic                lvl_mode,
    input  logic                ack,
    input  logic                masked,
    output logic                req,
    output logic [STATUS_W-1:0] status
);

    line_state_e state_q;
    line_state_e state_d;
    line_status_e status_d;
    logic        req_next;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (lvl_mode) begin
            state_d = samp ? LN_PEND_HI : LN_QUIET;
        end else begin
            unique case (state_q)
                LN_QUIET:   state_d = samp ? LN_PEND_HI : LN_QUIET;
                LN_HELD:    state_d = samp ? LN_HELD    : LN_QUIET;
                LN_PEND_LO: begin
                    if (samp)      state_d = LN_PEND_HI;
                    else if (ack)  state_d = LN_QUIET;
                    else           state_d = LN_PEND_LO;
                end
                LN_PEND_HI: begin
                    if (ack)       state_d = samp ? LN_HELD : LN_QUIET;
                    else           state_d = samp ? LN_PEND_HI : LN_PEND_LO;
                end
                default:           state_d = LN_QUIET;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decisions
    assign req_next = state_d[1];

    always_comb begin
        if (masked) begin
            status_d = ST_MASKED;
        end else if (req_next && !state_q[1]) begin
            status_d = ST_NEW;
        end else begin
            status_d = ST_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= ST_NONE;
        end else begin
            status <= status_d;
        end
    end

    assign req = state_q[1];

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_latch_pkg::*;
#(
    parameter int                  N_LINES    = 8,
    parameter logic [N_LINES-1:0]  TRIG_WMASK = 8'hF8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_LINES-1:0]            line_in,
    input  logic [N_LINES-1:0]            mask_in,
    input  logic [N_LINES-1:0]            ack_clr,
    input  logic                          trig_we,
    input  logic [N_LINES-1:0]            trig_wdata,
    output logic [N_LINES-1:0]            req_out,
    output logic [STATUS_W*N_LINES-1:0]   status_out
);

    localparam int STW = STATUS_W * N_LINES;

    logic [N_LINES-1:0] trig_q;
    logic [STW-1:0]     status_w;

    irq_trig_reg #(
        .N_LINES    (N_LINES),
        .TRIG_WMASK (TRIG_WMASK)
    ) u_trig (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (trig_we),
        .wr_data (trig_wdata),
        .mode_q  (trig_q)
    );

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        irq_line_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .samp     (line_in[gi]),
            .lvl_mode (trig_q[gi]),
            .ack      (ack_clr[gi]),
            .masked   (mask_in[gi]),
            .req      (req_out[gi]),
            .status   (status_w[STATUS_W*gi +: STATUS_W])
        );
    end

    assign status_out = status_w;

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int N_LINES = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [N_LINES-1:0]     line_in,
    input logic [N_LINES-1:0]     mask_in,
    input logic [N_LINES-1:0]     ack_clr,
    input logic [N_LINES-1:0]     req_out,
    input logic [2*N_LINES-1:0]   status_out,
    input logic [N_LINES-1:0]     mode_q
);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (req_out == '0 && status_out == '0));

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_chk
        a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
            mode_q[gi] |=> (req_out[gi] == $past(line_in[gi])));

        a_r5_fall_keeps: assert property (@(posedge clk) disable iff (rst)
            (!mode_q[gi] && req_out[gi] && !ack_clr[gi]) |=> req_out[gi]);

        a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (!mode_q[gi] && ack_clr[gi] && !line_in[gi]) |=> !req_out[gi]);

        a_r4_no_rearm: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !mode_q[gi] && !req_out[gi] && line_in[gi]
             && $past(line_in[gi])) |=> !req_out[gi]);

        a_r8_masked_status: assert property (@(posedge clk) disable iff (rst)
            mask_in[gi] |=> (status_out[2*gi +: 2] == 2'd2));

        a_r7_new_status: assert property (@(posedge clk) disable iff (rst)
            (!mask_in[gi] && !req_out[gi]) |=>
            ((status_out[2*gi +: 2] == 2'd1) == req_out[gi]));
    end

endmodule

bind irq_req_latch irq_req_latch_chk #(.N_LINES(N_LINES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_in    (line_in),
    .mask_in    (mask_in),
    .ack_clr    (ack_clr),
    .req_out    (req_out),
    .status_out (status_out),
    .mode_q     (trig_q)
);

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;

    localparam int   CLK_PERIOD = 10;
    localparam int   N          = 8;
    localparam logic [N-1:0] WMASK = 8'hF8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   line_in = '0;
    logic [N-1:0]   mask_in = '0;
    logic [N-1:0]   ack_clr = '0;
    logic           trig_we = 1'b0;
    logic [N-1:0]   trig_wdata = '0;
    logic [N-1:0]   req_out;
    logic [2*N-1:0] status_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model
    logic [N-1:0]   m_req = '0, m_last = '0, m_trig = '0;
    logic [2*N-1:0] m_stat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_req_latch #(.N_LINES(N), .TRIG_WMASK(WMASK)) u_irq_req_latch (
        .clk(clk), .rst(rst), .line_in(line_in), .mask_in(mask_in),
        .ack_clr(ack_clr), .trig_we(trig_we), .trig_wdata(trig_wdata),
        .req_out(req_out), .status_out(status_out)
    );

    task automatic model_update();
        logic [N-1:0] nreq;
        if (rst) begin
            m_req = '0; m_last = '0; m_trig = '0; m_stat = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (m_trig[i]) nreq[i] = line_in[i];
                else nreq[i] = (m_req[i] & ~ack_clr[i]) | (line_in[i] & ~m_last[i]);
                if (mask_in[i])                m_stat[2*i +: 2] = 2'd2;
                else if (nreq[i] && !m_req[i]) m_stat[2*i +: 2] = 2'd1;
                else                           m_stat[2*i +: 2] = 2'd0;
            end
            m_req  = nreq;
            m_last = line_in;
            if (trig_we) m_trig = trig_wdata & WMASK;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        model_update();
    endtask

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_model(input string tag);
        chk({24'd0, req_out}, {24'd0, m_req}, tag);
        chk({16'd0, status_out}, {16'd0, m_stat}, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        step(); step();
        rst = 1'b0;
        chk({24'd0, req_out}, 32'd0, "R1 req after reset");
        chk({16'd0, status_out}, 32'd0, "R1 status after reset");

        // R3: rising edge on edge-mode line 0
        line_in = 8'h01; step();
        chk({31'd0, req_out[0]}, 32'd1, "R3 edge sets");
        chk({30'd0, status_out[1:0]}, 32'd1, "R7 new status");
        step();
        chk({30'd0, status_out[1:0]}, 32'd0, "R7 status back to none");
        // R5: fall keeps request
        line_in = 8'h00; step();
        chk({31'd0, req_out[0]}, 32'd1, "R5 fall keeps request");
        // R6: acknowledge clears
        ack_clr = 8'h01; step(); ack_clr = '0;
        chk({31'd0, req_out[0]}, 32'd0, "R6 ack clears edge");
        // R4: held high after ack does not re-arm
        line_in = 8'h01; step();
        ack_clr = 8'h01; step(); ack_clr = '0;
        step(); step();
        chk({31'd0, req_out[0]}, 32'd0, "R4 held high no re-arm");
        line_in = 8'h00; step(); line_in = 8'h01; step();
        chk({31'd0, req_out[0]}, 32'd1, "R4 re-arm after low");
        // R6: fresh edge during ack wins (line 3 pending, seen low)
        line_in = 8'h08; step(); line_in = 8'h00; step();
        line_in = 8'h08; ack_clr = 8'h08; step(); ack_clr = '0;
        chk({31'd0, req_out[3]}, 32'd1, "R6 fresh edge beats ack");

        // R9: write all ones; lines 0..2 forced edge
        line_in = '0; ack_clr = 8'hFF; step(); ack_clr = '0;
        trig_we = 1'b1; trig_wdata = 8'hFF; step(); trig_we = 1'b0;
        line_in = 8'h12; step(); line_in = 8'h00; step();
        chk({31'd0, req_out[1]}, 32'd1, "R9 forced edge line keeps");
        chk({31'd0, req_out[4]}, 32'd0, "R2 level drops with input");
        line_in = 8'h10; step();
        chk({31'd0, req_out[4]}, 32'd1, "R2 level follows high");
        ack_clr = 8'h10; step(); ack_clr = '0;
        chk({31'd0, req_out[4]}, 32'd1, "R6 ack ignored in level");
        // R8: masked level line 5 still latches
        mask_in = 8'h20; line_in = 8'h30; step();
        chk({31'd0, req_out[5]}, 32'd1, "R8 masked still latches");
        chk({30'd0, status_out[11:10]}, 32'd2, "R8 masked status");
        mask_in = '0;
        // R4: switch line 4 to edge while high, ack, stay high
        trig_we = 1'b1; trig_wdata = 8'h00; step(); trig_we = 1'b0;
        ack_clr = 8'h10; step(); ack_clr = '0; step(); step();
        chk({31'd0, req_out[4]}, 32'd0, "R4 mode switch no re-arm");

        // Sweep against the model
        lfsr = 32'hACE1_1234;
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            line_in    = lfsr[7:0];
            mask_in    = lfsr[15:8] & lfsr[23:16];
            ack_clr    = lfsr[23:16];
            trig_we    = (lfsr[27:24] == 4'h5);
            trig_wdata = lfsr[31:24] ^ lfsr[7:0];
            rst        = (lfsr[31:20] == 12'h0A5);
            step();
            chk_model("R7 sweep");
        end
        rst = 1'b0; trig_we = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule